// File: doc/BRIEF.md
# Receiver Idle Timeout Counter

This block watches the gaps between characters arriving on a serial receive path and measures them in bit periods. The idle limit comes from a 16-bit value that software loads. Software issues a start command to arm the block. Arming alone does not start the count. Counting begins only when the next character arrives. Every later character restarts the count from the full value. If the count runs out, a sticky timeout flag is raised for the interrupt logic.

The flag therefore marks a silence that follows received data, not a free-running interval. It stays set until software arms the block again. The status-reset command, which clears other receive error flags elsewhere, leaves this flag and the count alone. The serial receiver itself lies outside this block. It provides a one-cycle character strobe and a one-cycle bit-period tick.

Top module: `rx_idle_timeout`

## Requirements
- R1: After reset the timeout flag is 0 and the block is disarmed.
- R2: Ticks have no effect until a start command has been followed by a character strobe. A character that arrives before any start command is ignored.
- R3: With a timeout value N other than zero, the flag rises on the clock edge that registers the N-th tick after the last character strobe. It is 0 after N-1 ticks.
- R4: A start command clears the flag on the next edge and re-arms the block, which then waits for a character again.
- R5: Once set, the flag stays set and ignores any characters and ticks until the next start command.
- R6: The status-reset command affects neither the flag nor an ongoing count.
- R7: Each character strobe during counting reloads the full timeout value.
- R8: A value of zero disables the timeout. A character that arrives while the value is zero neither starts nor reloads a count, and the flag never rises.
- R9: Values up to 65535 are counted exactly, including a typical setting of 2000 bit periods.
- R10: When a start command and a character strobe arrive in the same cycle, the start wins and the character is ignored.
- R11: When a character strobe and a tick arrive in the same cycle during counting, the reload wins and the tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_tick | input | 1 | One-cycle pulse per received bit period |
| char_rx | input | 1 | One-cycle pulse per received character |
| tmo_val | input | 16 | Idle limit in bit periods; 0 disables |
| start_cmd | input | 1 | Arm command; clears the flag |
| srst_cmd | input | 1 | Status-reset command; no effect here |
| tmo_flag | output | 1 | Sticky idle-timeout flag |

## Verification
The assertions assume that the tick and the character strobe are single-cycle pulses that come from the same clock domain. They also assume that the timeout value stays stable from one character to the next. The bench drives every input at the falling clock edge and pulses strobes for exactly one cycle. It changes the timeout value only while the block is disarmed or has expired. The cases where start and character coincide, and where character and tick coincide, are driven on purpose so that the assertions on priority are exercised.

// File: rtl/rto_pkg.sv
package rto_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } rto_state_e;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_SRST  = 2'd1,
    CMD_START = 2'd2,
    CMD_BOTH  = 2'd3
  } rto_cmd_e;

  typedef struct packed {
    logic load;
    logic dec;
  } rto_cnt_ctl_t;
endpackage

// File: rtl/rto_rst_sync.sv
module rto_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rto_down_cnt.sv
module rto_down_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rto_pkg::rto_cnt_ctl_t ctl,
  input  logic [CNT_W-1:0] load_val,
  output logic             at_last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = ctl.load | ctl.dec;
    if (ctl.load) cnt_d = load_val;
    else          cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign at_last = (cnt_q == ONE);
endmodule

// File: rtl/rto_ctrl.sv
module rto_ctrl (
  input  logic                  clk,
  input  logic                  rst_n,
  input  rto_pkg::rto_cmd_e     cmd,
  input  logic                  char_rx,
  input  logic                  bit_tick,
  input  logic                  val_zero,
  input  logic                  at_last,
  output rto_pkg::rto_cnt_ctl_t cnt_ctl,
  output logic                  expired
);
  import rto_pkg::*;

  rto_state_e state_q, state_d;
  logic       start_hit;

  always_comb begin
    unique case (cmd)
      CMD_START, CMD_BOTH: start_hit = 1'b1;
      CMD_SRST:            start_hit = 1'b0;
      default:             start_hit = 1'b0;
    endcase
  end

  always_comb begin
    state_d      = state_q;
    cnt_ctl.load = 1'b0;
    cnt_ctl.dec  = 1'b0;
    if (start_hit) begin
      state_d = ST_WAIT;
    end else begin
      unique case (state_q)
        ST_OFF:  state_d = ST_OFF;
        ST_WAIT: begin
          if (char_rx && !val_zero) begin
            state_d      = ST_RUN;
            cnt_ctl.load = 1'b1;
          end
        end
        ST_RUN: begin
          if (char_rx) begin
            if (val_zero) state_d = ST_WAIT;
            else          cnt_ctl.load = 1'b1;
          end else if (bit_tick) begin
            if (at_last) state_d = ST_DONE;
            else         cnt_ctl.dec = 1'b1;
          end
        end
        ST_DONE: state_d = ST_DONE;
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  assign expired = (state_q == ST_DONE);
endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             char_rx,
  input  logic [CNT_W-1:0] tmo_val,
  input  logic             start_cmd,
  input  logic             srst_cmd,
  output logic             tmo_flag
);
  import rto_pkg::*;

  logic          rst_int_n;
  rto_cmd_e      cmd;
  rto_cnt_ctl_t  cnt_ctl;
  logic          at_last;
  logic          val_zero;

  rto_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign cmd      = rto_cmd_e'({start_cmd, srst_cmd});
  assign val_zero = (tmo_val == '0);

  rto_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cmd      (cmd),
    .char_rx  (char_rx),
    .bit_tick (bit_tick),
    .val_zero (val_zero),
    .at_last  (at_last),
    .cnt_ctl  (cnt_ctl),
    .expired  (tmo_flag)
  );

  rto_down_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ctl      (cnt_ctl),
    .load_val (tmo_val),
    .at_last  (at_last)
  );
endmodule

// File: rtl/rto_checker.sv
module rto_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_tick,
  input logic             char_rx,
  input logic [CNT_W-1:0] tmo_val,
  input logic             start_cmd,
  input logic             srst_cmd,
  input logic             tmo_flag
);
  // R4: arming clears the flag on the next edge
  assert_start_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_cmd |=> !tmo_flag);

  // R5: the flag holds until the next start command
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !start_cmd) |=> tmo_flag);

  // R6: status reset alone leaves a set flag untouched
  assert_srst_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && srst_cmd && !start_cmd) |=> tmo_flag);

  // R3: expiry happens only on a tick
  assert_rise_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> $past(bit_tick));

  // R11: a character in the same cycle blocks expiry
  assert_char_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> !$past(char_rx));

  // R10: a start in the expiry cycle wins
  assert_start_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> !$past(start_cmd));

  // R8: zero value never expires
  assert_zero_disables_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> ($past(tmo_val) != '0));
endmodule

bind rx_idle_timeout rto_checker #(.CNT_W(CNT_W)) u_rto_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_tick  (bit_tick),
  .char_rx   (char_rx),
  .tmo_val   (tmo_val),
  .start_cmd (start_cmd),
  .srst_cmd  (srst_cmd),
  .tmo_flag  (tmo_flag)
);

// File: tb/rx_idle_timeout_tb.sv
`timescale 1ns/1ps
module rx_idle_timeout_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_tick = 1'b0;
  logic        char_rx = 1'b0;
  logic [15:0] tmo_val = 16'd0;
  logic        start_cmd = 1'b0;
  logic        srst_cmd = 1'b0;
  logic        tmo_flag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rx_idle_timeout u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .char_rx(char_rx),
    .tmo_val(tmo_val), .start_cmd(start_cmd), .srst_cmd(srst_cmd),
    .tmo_flag(tmo_flag)
  );

  task automatic check(input string req, input logic exp);
    n_chk++;
    if (tmo_flag !== exp) begin
      n_fail++;
      $display("FAIL %s: tmo_flag=%b expected %b at %0t", req, tmo_flag, exp, $time);
    end
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      bit_tick = 1'b1;
      repeat (n) @(negedge clk);
      bit_tick = 1'b0;
    end
  endtask

  task automatic pulse_start();
    start_cmd = 1'b1; @(negedge clk); start_cmd = 1'b0;
  endtask

  task automatic pulse_char();
    char_rx = 1'b1; @(negedge clk); char_rx = 1'b0;
  endtask

  task automatic pulse_srst();
    srst_cmd = 1'b1; @(negedge clk); srst_cmd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", 1'b0);

    // R2: character before any start, then ticks
    tmo_val = 16'd3;
    pulse_char(); ticks(10);
    check("R2", 1'b0);

    // R3 basic with N=5
    tmo_val = 16'd5;
    pulse_start(); pulse_char(); ticks(4);
    check("R3", 1'b0);
    ticks(1);
    check("R3", 1'b1);

    // R5: sticky against ticks and characters
    pulse_char(); ticks(7); pulse_char();
    check("R5", 1'b1);
    // R6: status reset leaves flag
    pulse_srst();
    check("R6", 1'b1);
    // R4: start clears
    pulse_start();
    check("R4", 1'b0);
    // R2: armed but no character
    ticks(20);
    check("R2", 1'b0);

    // R6: status reset mid-count does not disturb count
    pulse_char(); ticks(2); pulse_srst(); ticks(2);
    check("R6", 1'b0);
    ticks(1);
    check("R6", 1'b1);

    // R7: reload on character
    pulse_start(); pulse_char(); ticks(3); pulse_char(); ticks(4);
    check("R7", 1'b0);
    ticks(1);
    check("R7", 1'b1);

    // R8: zero disables
    tmo_val = 16'd0;
    pulse_start(); pulse_char(); ticks(100);
    check("R8", 1'b0);

    // R3 sweep N=1..8
    for (int n = 1; n <= 8; n++) begin
      tmo_val = 16'(n);
      pulse_start(); pulse_char(); ticks(n - 1);
      check("R3", 1'b0);
      ticks(1);
      check("R3", 1'b1);
    end

    // R9: large value
    tmo_val = 16'd2000;
    pulse_start(); pulse_char(); ticks(1999);
    check("R9", 1'b0);
    ticks(1);
    check("R9", 1'b1);

    // R10: start and character together; character ignored
    tmo_val = 16'd4;
    start_cmd = 1'b1; char_rx = 1'b1; @(negedge clk);
    start_cmd = 1'b0; char_rx = 1'b0;
    ticks(10);
    check("R10", 1'b0);
    pulse_char(); ticks(4);
    check("R10", 1'b1);

    // R11: character and tick together reload, tick not counted
    pulse_start(); pulse_char(); ticks(3);
    char_rx = 1'b1; bit_tick = 1'b1; @(negedge clk);
    char_rx = 1'b0; bit_tick = 1'b0;
    ticks(3);
    check("R11", 1'b0);
    ticks(1);
    check("R11", 1'b1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule